// File: doc/BRIEF.md
# Bus Ownership Grant Controller

This block sits on the processor side of a three-signal bus handover: request, grant and grant-acknowledge. Any number of external masters pull a shared request line, so the block sees only that someone wants the bus. It answers with a grant and releases the bus. From the moment the grant goes out until the bus comes back it holds a stall line high toward the processor's own bus engine. Picking which external master wins is left to arbitration logic outside the block.

The request and acknowledge inputs are asynchronous. Each passes through its own flop synchronizer before the state machine uses it. A grant waits for any internal bus cycle that is already running, unless the processor is in reset, halted, or stopped after a double fault. In those states the engine issues no cycles, so the grant goes out at once. Once acknowledge is seen, the grant is dropped after a fixed delay. If the request line is still active, a fresh grant follows after a second fixed delay. The next master is then chosen while the current one still drives the bus. When acknowledge is released, the processor takes the bus back, or it grants again if a request is still pending.

Top module: `bus_grant_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycles after it rises, `grant` and `cpu_stall` are both 0.
- R2: With `ext_req` held high from idle and no busy cycle, `grant` goes high on the third rising clock edge after `ext_req` rises: two synchronizer stages plus the state register. `cpu_stall` rises on the same edge.
- R3: While `cycle_busy` is high and none of `core_rst`, `core_halt`, `core_dfault` is high, no grant is issued from idle. The grant follows once `cycle_busy` has been low at an edge where the synchronized request is high.
- R4: While any of `core_rst`, `core_halt` or `core_dfault` is high, `cycle_busy` is ignored and a pending request is granted as in R2.
- R5: Once the synchronized acknowledge is seen while granting, `grant` stays high for ACK_DLY more cycles (default 2) and then falls. `cpu_stall` stays high.
- R6: While acknowledge stays high and the request line is still active after the grant has fallen, `grant` goes high again after exactly REGRANT_DLY cycles low (default 2).
- R7: When the synchronized acknowledge falls and no request is pending, `grant` and `cpu_stall` both go low, and the processor resumes. `cpu_stall` never falls while the synchronized acknowledge is high.
- R8: When the synchronized acknowledge falls while a request is pending, `grant` is high on the next cycle and `cpu_stall` stays high.
- R9: If the request drops before any acknowledge is seen, `grant` is withdrawn and `cpu_stall` goes low. The processor keeps the bus.
- R10: `cpu_stall` is high in every cycle in which `grant` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| ext_req | input | 1 | Wired-OR bus request from all external masters, asynchronous, active high |
| ext_ack | input | 1 | Grant acknowledge from the current external owner, asynchronous, active high |
| core_rst | input | 1 | Processor is held in reset |
| core_halt | input | 1 | Processor is halted |
| core_dfault | input | 1 | Processor has stopped after a double bus fault |
| cycle_busy | input | 1 | Internal bus cycle in progress |
| grant | output | 1 | Bus grant, active high |
| cpu_stall | output | 1 | Holds the internal bus engine off while the bus is lent out |

## Verification
The hardest situation to reach is the early re-grant. It needs acknowledge held high while the request line stays active past the grant drop, and then a handover in which acknowledge falls with the request still pending. A directed sequence builds exactly this case with two overlapping masters and measures the low gap of the grant in cycles. A seeded random phase then plays master behaviour with random acknowledge lengths, random pending requests, random busy cycles and random halt states. A last phase drives every input randomly so that requests drop in mid-handover. An independent cycle model in the bench is compared with both outputs on every cycle.

// File: rtl/bgc_pkg.sv
package bgc_pkg;

  typedef enum logic [2:0] {
    ST_OWN      = 3'd0,
    ST_OFFER    = 3'd1,
    ST_HOLD     = 3'd2,
    ST_EXT      = 3'd3,
    ST_PREOFFER = 3'd4
  } bgc_state_e;

  function automatic logic grant_of(bgc_state_e s);
    return (s == ST_OFFER) || (s == ST_HOLD) || (s == ST_PREOFFER);
  endfunction

  function automatic logic stall_of(bgc_state_e s);
    return s != ST_OWN;
  endfunction

  function automatic int cnt_width(int a, int b);
    int m;
    m = (a > b) ? a : b;
    return $clog2(m + 1) + 1;
  endfunction

endpackage

// File: rtl/bgc_sync.sv
module bgc_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] pipe [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[0] <= '0;
          else        pipe[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[i] <= '0;
          else        pipe[i] <= pipe[i-1];
        end
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/bgc_timer.sv
module bgc_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          en,
  input  logic [CW-1:0] limit,
  output logic          hit
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (en)    cnt_q <= cnt_q + 1'b1;
  end

  assign hit = (cnt_q == limit);

  // R5 / R6: the delay counter never runs past its programmed limit
  assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q <= limit));

endmodule

// File: rtl/bgc_fsm.sv
module bgc_fsm
  import bgc_pkg::*;
#(
  parameter int ACK_DLY     = 2,
  parameter int REGRANT_DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_s,
  input  logic ack_s,
  input  logic busy_eff,
  output logic grant_w,
  output logic stall_w
);

  localparam int CW = cnt_width(ACK_DLY, REGRANT_DLY);
  localparam logic [CW-1:0] ACK_LIM = CW'(ACK_DLY - 1);
  localparam logic [CW-1:0] RG_LIM  = CW'(REGRANT_DLY - 1);

  bgc_state_e    state_q, state_d;
  logic          hit, cnt_clear, cnt_en;
  logic [CW-1:0] cnt_limit;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OWN:      if (req_s && !busy_eff) state_d = ST_OFFER;
      ST_OFFER:    if (ack_s)              state_d = ST_HOLD;
                   else if (!req_s)        state_d = ST_OWN;
      ST_HOLD:     if (hit)                state_d = ST_EXT;
      ST_EXT:      if (!ack_s)             state_d = req_s ? ST_OFFER : ST_OWN;
                   else if (req_s && hit)  state_d = ST_PREOFFER;
      ST_PREOFFER: if (!ack_s)             state_d = ST_OFFER;
                   else if (!req_s)        state_d = ST_EXT;
      default:                             state_d = ST_OWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OWN;
    else        state_q <= state_d;
  end

  assign cnt_clear = (state_d != state_q) || (state_q == ST_EXT && !req_s);
  assign cnt_en    = (state_q == ST_HOLD) || (state_q == ST_EXT && req_s);
  assign cnt_limit = (state_q == ST_HOLD) ? ACK_LIM : RG_LIM;

  bgc_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (cnt_clear),
    .en    (cnt_en),
    .limit (cnt_limit),
    .hit   (hit)
  );

  assign grant_w = grant_of(state_q);
  assign stall_w = stall_of(state_q);

  assert_grant_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_w) |-> $past(req_s));

  assert_busy_holds_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OWN && busy_eff) |=> !grant_w);

  assert_release_needs_ack_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall_w) |-> !$past(ack_s));

  assert_withdraw_on_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OFFER && !req_s && !ack_s) |=> (!grant_w && !stall_w));

  assert_stall_covers_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    grant_w |-> stall_w);

endmodule

// File: rtl/bus_grant_ctrl.sv
module bus_grant_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int ACK_DLY     = 2,
  parameter int REGRANT_DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_req,
  input  logic ext_ack,
  input  logic core_rst,
  input  logic core_halt,
  input  logic core_dfault,
  input  logic cycle_busy,
  output logic grant,
  output logic cpu_stall
);

  logic [1:0] raw_in, synced;
  logic       req_s, ack_s, engine_stopped, busy_eff;

  assign raw_in = {ext_ack, ext_req};

  bgc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (raw_in),
    .dout  (synced)
  );

  assign req_s = synced[0];
  assign ack_s = synced[1];

  // A stopped engine runs no cycles, so a busy flag cannot delay the grant
  assign engine_stopped = core_rst | core_halt | core_dfault;
  assign busy_eff       = cycle_busy & ~engine_stopped;

  bgc_fsm #(.ACK_DLY(ACK_DLY), .REGRANT_DLY(REGRANT_DLY)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_s    (req_s),
    .ack_s    (ack_s),
    .busy_eff (busy_eff),
    .grant_w  (grant),
    .stall_w  (cpu_stall)
  );

  // R4: a stopped engine never blocks a grant on a busy flag
  assert_stopped_ignores_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (engine_stopped && cycle_busy) |-> !busy_eff);

endmodule

// File: tb/bus_grant_ctrl_bench.sv
module bus_grant_ctrl_bench;

  localparam int SYNC_STAGES = 2;
  localparam int ACK_DLY     = 2;
  localparam int REGRANT_DLY = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_req = 1'b0, ext_ack = 1'b0;
  logic core_rst = 1'b0, core_halt = 1'b0, core_dfault = 1'b0, cycle_busy = 1'b0;
  logic grant, cpu_stall;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;
  bit rnd_side = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bus_grant_ctrl #(.SYNC_STAGES(SYNC_STAGES), .ACK_DLY(ACK_DLY), .REGRANT_DLY(REGRANT_DLY))
  u_bus_grant_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .ext_ack(ext_ack),
    .core_rst(core_rst), .core_halt(core_halt), .core_dfault(core_dfault),
    .cycle_busy(cycle_busy), .grant(grant), .cpu_stall(cpu_stall)
  );

  // ---- independent cycle model: 0 idle, 1 offered, 2 ack seen, 3 lent, 4 offered early
  int  m_st = 0, m_prev = 0, m_cnt = 0;
  logic mr1 = 0, mr2 = 0, ma1 = 0, ma2 = 0;

  function automatic int model_next(int st, logic rq, logic ak, logic bz, int cnt);
    case (st)
      0: return (rq && !bz) ? 1 : 0;
      1: return ak ? 2 : (!rq ? 0 : 1);
      2: return (cnt + 1 >= ACK_DLY) ? 3 : 2;
      3: if (!ak) return rq ? 1 : 0;
         else return (rq && cnt + 1 >= REGRANT_DLY) ? 4 : 3;
      default: return !ak ? 1 : (!rq ? 3 : 4);
    endcase
  endfunction

  function automatic int model_cnt(int st, int nx, logic rq, int cnt);
    if (nx != st) return 0;
    if (st == 2) return cnt + 1;
    if (st == 3) return rq ? cnt + 1 : 0;
    return cnt;
  endfunction

  function automatic logic exp_grant(int st);
    return st == 1 || st == 2 || st == 4;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr1 <= 0; mr2 <= 0; ma1 <= 0; ma2 <= 0; m_st <= 0; m_prev <= 0; m_cnt <= 0;
    end else begin
      int nx;
      logic bz;
      bz = cycle_busy && !(core_rst || core_halt || core_dfault);
      nx = model_next(m_st, mr2, ma2, bz, m_cnt);
      mr1 <= ext_req; mr2 <= mr1; ma1 <= ext_ack; ma2 <= ma1;
      m_cnt <= model_cnt(m_st, nx, mr2, m_cnt);
      m_prev <= m_st;
      m_st <= nx;
    end
  end

  task automatic check(string tag, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic string tag_now();
    if (m_prev == 3 && m_st == 1) return "R8";
    if (m_prev == 1 && m_st == 0) return "R9";
    if (m_prev == 3 && m_st == 0) return "R7";
    if (m_st == 0 && cycle_busy && (core_rst || core_halt || core_dfault)) return "R4";
    if (m_st == 0 && cycle_busy) return "R3";
    if (m_st == 2) return "R5";
    if (m_st == 3 || m_st == 4) return "R6";
    return "R2";
  endfunction

  // continuous comparison against the model, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!done) begin
      if (!rst_n) begin
        check("R1", grant, 1'b0, "grant in reset");
        check("R1", cpu_stall, 1'b0, "stall in reset");
      end else begin
        check(tag_now(), grant, exp_grant(m_st), "grant vs model");
        check(tag_now(), cpu_stall, m_st != 0, "stall vs model");
        if (grant && !cpu_stall) check("R10", 1'b0, 1'b1, "stall covers grant");
      end
      if (rnd_side) begin
        cycle_busy  <= ($urandom % 10) < 3;
        core_halt   <= ($urandom % 20) == 0;
        core_rst    <= ($urandom % 40) == 0;
        core_dfault <= ($urandom % 40) == 0;
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_grant(logic val, int lim);
    for (int i = 0; i < lim; i++) begin
      if (grant === val) return;
      tick();
    end
  endtask

  initial begin
    int len;
    void'($urandom(32'h1A2B3C4D));
    tick(3);
    rst_n = 1'b1;
    tick(2);
    check("R1", grant, 1'b0, "grant after reset");
    check("R1", cpu_stall, 1'b0, "stall after reset");

    // R2 latency: request rises, grant on third edge
    ext_req = 1'b1;
    tick(2);
    check("R2", grant, 1'b0, "grant before sync settles");
    tick();
    check("R2", grant, 1'b1, "grant on third edge");
    check("R2", cpu_stall, 1'b1, "stall with grant");

    // R5: ack -> grant drop after ACK_DLY+3 ticks
    ext_ack = 1'b1;
    ext_req = 1'b0;
    len = 0;
    for (int i = 0; i < 20 && grant; i++) begin tick(); len++; end
    check("R5", len == ACK_DLY + 3, 1'b1, "ack to grant drop ticks");
    check("R5", cpu_stall, 1'b1, "stall while lent");
    ext_ack = 1'b0;
    tick(4);
    check("R7", cpu_stall, 1'b0, "bus reclaimed");
    check("R7", grant, 1'b0, "no grant after release");

    // R3: busy holds off grant
    cycle_busy = 1'b1;
    ext_req = 1'b1;
    tick(8);
    check("R3", grant, 1'b0, "held off by busy");
    cycle_busy = 1'b0;
    tick(2);
    check("R3", grant, 1'b1, "granted after busy ends");
    // R9: request drops before ack
    ext_req = 1'b0;
    tick(4);
    check("R9", grant, 1'b0, "grant withdrawn");
    check("R9", cpu_stall, 1'b0, "processor keeps bus");

    // R4: stopped states ignore busy
    cycle_busy = 1'b1;
    for (int k = 0; k < 3; k++) begin
      core_halt = (k == 0); core_rst = (k == 1); core_dfault = (k == 2);
      ext_req = 1'b1;
      tick(4);
      check("R4", grant, 1'b1, "granted while stopped and busy");
      ext_req = 1'b0;
      tick(4);
    end
    core_halt = 0; core_rst = 0; core_dfault = 0; cycle_busy = 0;

    // R6 / R8: early re-grant with two masters
    ext_req = 1'b1;
    wait_grant(1'b1, 20);
    ext_ack = 1'b1;
    wait_grant(1'b0, 20);
    len = 0;
    for (int i = 0; i < 20 && !grant; i++) begin tick(); len++; end
    check("R6", len == REGRANT_DLY, 1'b1, "re-grant gap cycles");
    ext_ack = 1'b0;
    tick(3);
    check("R8", grant, 1'b1, "grant after handover");
    check("R8", cpu_stall, 1'b1, "stall kept at handover");
    ext_ack = 1'b1;
    ext_req = 1'b0;
    tick(10);
    ext_ack = 1'b0;
    tick(5);
    check("R7", cpu_stall, 1'b0, "bus back after last master");

    // protocol-like random masters with random side conditions
    rnd_side = 1'b1;
    for (int t = 0; t < 150; t++) begin
      ext_req = 1'b1;
      wait_grant(1'b1, 60);
      tick($urandom % 4);
      ext_ack = 1'b1;
      ext_req = ($urandom % 2) == 1;
      tick(1 + $urandom % 12);
      ext_ack = 1'b0;
      if (($urandom % 3) == 0) ext_req = 1'b0;
      tick($urandom % 5);
    end

    // fully random inputs
    for (int t = 0; t < 3000; t++) begin
      if (($urandom % 4) == 0) ext_req = $urandom % 2;
      if (($urandom % 4) == 0) ext_ack = $urandom % 2;
      tick();
    end
    rnd_side = 1'b0;
    ext_req = 0; ext_ack = 0;
    tick(5);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule